// File: doc/BRIEF.md
# Segmented Word Stack Engine

This block keeps the stack of a small 16-bit processor in a byte-wide memory. The stack grows downwards. The block holds a 16-bit stack pointer and a 16-bit stack segment. The core issues one command at a time: push a word, pop a word, call, return, interrupt entry or interrupt return. The engine then moves the words one byte per cycle over a single-port memory port.

Every memory address is the segment multiplied by sixteen plus a 16-bit pointer offset. A word is split into a high byte, which sits just below the pointer, and a low byte one address lower. For a call or an interrupt, the engine gives the new program counter (and code segment) back to the core. A return or interrupt return instead restores the program counter, code segment and flags from the stack.

The core can also load the pointer and segment directly while the engine is idle.

Top module: `stk_engine`

## Requirements
- R1: A push (cmd_op 0) writes the high byte of cmd_data at offset SP-1 in the first busy cycle. It writes the low byte at offset SP-2 in the second busy cycle. It lowers SP by 2 only after the second write. mem_we is high in both cycles.
- R2: A pop (cmd_op 1) reads the low byte at offset SP in the first busy cycle and the high byte at offset SP+1 in the second. It then raises SP by 2 and shows the word on pop_word. mem_rdata is sampled in the same cycle that the address is driven.
- R3: mem_addr equals SS*16 plus the pointer offset, taken modulo 2^20. The offset itself (SP-1, SP-2, SP, SP+1) and SP are taken modulo 2^16. No overflow check is made.
- R4: A call (cmd_op 2) pushes cmd_ret_pc as in R1. pc_out then shows cmd_tgt_pc.
- R5: A return (cmd_op 3) pops one word as in R2 and shows it on pc_out.
- R6: Interrupt entry (cmd_op 4) pushes three words, each as in R1: first cmd_flags, then cmd_cs, then cmd_ret_pc. This takes six busy cycles. pc_out then shows cmd_tgt_pc and cs_out shows cmd_tgt_cs.
- R7: Interrupt return (cmd_op 5) pops three words. The first goes to pc_out, the second to cs_out and the third to flags_out.
- R8: busy is high from the cycle after a command is accepted through its last byte cycle. done is a one-cycle pulse in the cycle after the last byte. While busy is high there is exactly one memory access per cycle; while it is low there is none.
- R9: Commands presented while busy is high are ignored. Opcodes 6 and 7 are ignored: no access, no busy, and SP is unchanged.
- R10: After reset SP and SS hold the parameters SP_RST and SS_RST, and the result outputs read zero. While idle, sp_wr loads SP from wr_data and ss_wr loads SS from wr_data. A write is ignored in a cycle where a command is accepted, and while the engine is busy.
- R11: pop_word, pc_out, cs_out and flags_out keep their values from the done pulse until a later command updates them. Commands that do not target an output leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 3 | Command code (0 push, 1 pop, 2 call, 3 return, 4 interrupt entry, 5 interrupt return) |
| cmd_data | input | 16 | Word to push |
| cmd_ret_pc | input | 16 | Return offset pushed by call and interrupt entry |
| cmd_cs | input | 16 | Current code segment pushed by interrupt entry |
| cmd_flags | input | 16 | Flags word pushed by interrupt entry |
| cmd_tgt_pc | input | 16 | New program counter for call and interrupt entry |
| cmd_tgt_cs | input | 16 | New code segment for interrupt entry |
| sp_wr | input | 1 | Load SP from wr_data when idle |
| ss_wr | input | 1 | Load SS from wr_data when idle |
| wr_data | input | 16 | Direct load value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Current stack pointer |
| ss_out | output | 16 | Current stack segment |
| pop_word | output | 16 | Word from the last pop |
| pc_out | output | 16 | Program counter handed back to the core |
| cs_out | output | 16 | Code segment handed back to the core |
| flags_out | output | 16 | Flags restored by interrupt return |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as mem_addr |

## Verification
The bench builds the engine with SP_RST = 16'h0002 and SS_RST = 16'hFFFF. With these values the second push after reset wraps the pointer offset from 0000 to FFFF. In the same access, the physical address runs past the top of the 20-bit space, so both wrap rules are exercised without a long walk. A later directed load through the write port moves the stack into ordinary territory, and the random mix then runs from there with occasional random pointer loads.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int WORD_W    = 16;
    localparam int SEG_SHIFT = 4;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_INT  = 3'd4,
        OP_IRET = 3'd5
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    // pointer offset selector for address formation
    typedef enum logic [1:0] {
        OFS_AT  = 2'd0,
        OFS_P1  = 2'd1,
        OFS_M1  = 2'd2,
        OFS_M2  = 2'd3
    } ofs_e;
endpackage

// File: rtl/stk_addr_gen.sv
module stk_addr_gen #(
    parameter int WW    = stk_pkg::WORD_W,
    parameter int SHIFT = stk_pkg::SEG_SHIFT,
    localparam int AW   = WW + SHIFT
) (
    input  logic [WW-1:0]    seg,
    input  logic [WW-1:0]    ptr,
    input  stk_pkg::ofs_e    sel,
    output logic [AW-1:0]    phys
);
    logic [WW-1:0] ofs;
    logic [AW-1:0] base;

    always_comb begin
        unique case (sel)
            stk_pkg::OFS_AT: ofs = ptr;
            stk_pkg::OFS_P1: ofs = ptr + WW'(1);
            stk_pkg::OFS_M1: ofs = ptr - WW'(1);
            default:         ofs = ptr - WW'(2);
        endcase
        base = {seg, {SHIFT{1'b0}}};
        phys = base + {{SHIFT{1'b0}}, ofs};
    end
endmodule

// File: rtl/stk_frame_plan.sv
module stk_frame_plan #(
    parameter int WW = stk_pkg::WORD_W
) (
    input  stk_pkg::op_e  op,
    input  logic [1:0]    idx,
    input  logic [WW-1:0] push_data,
    input  logic [WW-1:0] ret_pc,
    input  logic [WW-1:0] cur_cs,
    input  logic [WW-1:0] flags,
    output logic [1:0]    nwords,
    output logic          is_push,
    output logic [WW-1:0] word
);
    always_comb begin
        nwords  = 2'd1;
        is_push = 1'b0;
        word    = '0;
        unique case (op)
            stk_pkg::OP_PUSH: begin
                is_push = 1'b1;
                word    = push_data;
            end
            stk_pkg::OP_CALL: begin
                is_push = 1'b1;
                word    = ret_pc;
            end
            stk_pkg::OP_INT: begin
                is_push = 1'b1;
                nwords  = 2'd3;
                unique case (idx)
                    2'd0:    word = flags;
                    2'd1:    word = cur_cs;
                    default: word = ret_pc;
                endcase
            end
            stk_pkg::OP_IRET: nwords = 2'd3;
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_byte_lane.sv
module stk_byte_lane #(
    parameter int WW = stk_pkg::WORD_W,
    localparam int BW = WW / 2
) (
    input  logic          phase,
    input  logic [WW-1:0] word_out,
    input  logic [BW-1:0] rd_byte,
    input  logic [BW-1:0] lo_byte,
    output logic [BW-1:0] wr_byte,
    output logic [WW-1:0] word_in
);
    // write order: high byte first, low byte second
    assign wr_byte = phase ? word_out[BW-1:0] : word_out[WW-1:BW];
    // read order: low byte captured first, high byte arrives second
    assign word_in = {rd_byte, lo_byte};
endmodule

// File: rtl/stk_engine.sv
module stk_engine #(
    parameter int WW              = stk_pkg::WORD_W,
    parameter int SHIFT           = stk_pkg::SEG_SHIFT,
    parameter logic [WW-1:0] SP_RST = 16'h8000,
    parameter logic [WW-1:0] SS_RST = 16'h0000,
    localparam int AW             = WW + SHIFT,
    localparam int BW             = WW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [WW-1:0] cmd_data,
    input  logic [WW-1:0] cmd_ret_pc,
    input  logic [WW-1:0] cmd_cs,
    input  logic [WW-1:0] cmd_flags,
    input  logic [WW-1:0] cmd_tgt_pc,
    input  logic [WW-1:0] cmd_tgt_cs,
    input  logic          sp_wr,
    input  logic          ss_wr,
    input  logic [WW-1:0] wr_data,
    output logic          busy,
    output logic          done,
    output logic [WW-1:0] sp_out,
    output logic [WW-1:0] ss_out,
    output logic [WW-1:0] pop_word,
    output logic [WW-1:0] pc_out,
    output logic [WW-1:0] cs_out,
    output logic [WW-1:0] flags_out,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic          mem_re,
    output logic [BW-1:0] mem_wdata,
    input  logic [BW-1:0] mem_rdata
);
    import stk_pkg::*;

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic [1:0]    wcnt;
        logic          bph;
        logic [WW-1:0] sp;
        logic [WW-1:0] ss;
        logic [BW-1:0] lo;
        logic [WW-1:0] d_push;
        logic [WW-1:0] d_ret;
        logic [WW-1:0] d_cs;
        logic [WW-1:0] d_flags;
        logic [WW-1:0] t_pc;
        logic [WW-1:0] t_cs;
        logic [WW-1:0] pop;
        logic [WW-1:0] pc;
        logic [WW-1:0] cs;
        logic [WW-1:0] flg;
        logic          done;
    } eng_t;

    eng_t q, d;

    logic [1:0]    nwords;
    logic          is_push;
    logic [WW-1:0] frame_word;
    logic [WW-1:0] word_in;
    logic [BW-1:0] wr_byte;
    ofs_e          sel;
    logic          we_c, re_c, accept, last_w;

    stk_frame_plan #(.WW(WW)) u_plan (
        .op        (q.op),
        .idx       (q.wcnt),
        .push_data (q.d_push),
        .ret_pc    (q.d_ret),
        .cur_cs    (q.d_cs),
        .flags     (q.d_flags),
        .nwords    (nwords),
        .is_push   (is_push),
        .word      (frame_word)
    );

    stk_byte_lane #(.WW(WW)) u_lane (
        .phase    (q.bph),
        .word_out (frame_word),
        .rd_byte  (mem_rdata),
        .lo_byte  (q.lo),
        .wr_byte  (wr_byte),
        .word_in  (word_in)
    );

    stk_addr_gen #(.WW(WW), .SHIFT(SHIFT)) u_addr (
        .seg  (q.ss),
        .ptr  (q.sp),
        .sel  (sel),
        .phys (mem_addr)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        we_c   = 1'b0;
        re_c   = 1'b0;
        sel    = OFS_AT;
        accept = (q.st == ST_IDLE) && cmd_valid && (cmd_op <= 3'd5);
        last_w = (q.wcnt == (nwords - 2'd1));
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st      = ST_RUN;
                    d.op      = op_e'(cmd_op);
                    d.wcnt    = 2'd0;
                    d.bph     = 1'b0;
                    d.d_push  = cmd_data;
                    d.d_ret   = cmd_ret_pc;
                    d.d_cs    = cmd_cs;
                    d.d_flags = cmd_flags;
                    d.t_pc    = cmd_tgt_pc;
                    d.t_cs    = cmd_tgt_cs;
                end else begin
                    if (sp_wr) d.sp = wr_data;
                    if (ss_wr) d.ss = wr_data;
                end
            end
            default: begin
                if (is_push) begin
                    we_c = 1'b1;
                    sel  = q.bph ? OFS_M2 : OFS_M1;
                    if (q.bph) d.sp = q.sp - WW'(2);
                end else begin
                    re_c = 1'b1;
                    sel  = q.bph ? OFS_P1 : OFS_AT;
                    if (!q.bph) begin
                        d.lo = mem_rdata;
                    end else begin
                        d.sp = q.sp + WW'(2);
                        unique case (q.op)
                            OP_POP: d.pop = word_in;
                            OP_RET: d.pc  = word_in;
                            default: begin
                                unique case (q.wcnt)
                                    2'd0:    d.pc  = word_in;
                                    2'd1:    d.cs  = word_in;
                                    default: d.flg = word_in;
                                endcase
                            end
                        endcase
                    end
                end
                d.bph = ~q.bph;
                if (q.bph) begin
                    d.wcnt = q.wcnt + 2'd1;
                    if (last_w) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        if (q.op == OP_CALL) d.pc = q.t_pc;
                        if (q.op == OP_INT) begin
                            d.pc = q.t_pc;
                            d.cs = q.t_cs;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.sp <= SP_RST;
            q.ss <= SS_RST;
        end else begin
            q    <= d;
        end
    end

    assign busy      = (q.st == ST_RUN);
    assign done      = q.done;
    assign sp_out    = q.sp;
    assign ss_out    = q.ss;
    assign pop_word  = q.pop;
    assign pc_out    = q.pc;
    assign cs_out    = q.cs;
    assign flags_out = q.flg;
    assign mem_we    = we_c;
    assign mem_re    = re_c;
    assign mem_wdata = wr_byte;
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter int WW    = stk_pkg::WORD_W,
    parameter int SHIFT = stk_pkg::SEG_SHIFT,
    localparam int AW   = WW + SHIFT
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          cmd_valid,
    input logic          sp_wr,
    input logic [WW-1:0] sp_out,
    input logic [WW-1:0] ss_out,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re,
    input logic [WW-1:0] pop_word,
    input logic [WW-1:0] pc_out,
    input logic [WW-1:0] cs_out,
    input logic [WW-1:0] flags_out
);
    logic [WW-1:0] sp_m1, sp_m2, sp_p1;
    logic [AW-1:0] base, a_m1, a_m2, a_at, a_p1;

    assign sp_m1 = sp_out - WW'(1);
    assign sp_m2 = sp_out - WW'(2);
    assign sp_p1 = sp_out + WW'(1);
    assign base  = {ss_out, {SHIFT{1'b0}}};
    assign a_m1  = base + {{SHIFT{1'b0}}, sp_m1};
    assign a_m2  = base + {{SHIFT{1'b0}}, sp_m2};
    assign a_at  = base + {{SHIFT{1'b0}}, sp_out};
    assign a_p1  = base + {{SHIFT{1'b0}}, sp_p1};

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_we || mem_re)); // R8

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_we ^ mem_re)); // R8

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy)); // R8

    AST_WR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr == a_m1) || (mem_addr == a_m2))); // R1

    AST_RD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> ((mem_addr == a_at) || (mem_addr == a_p1))); // R2

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid && !sp_wr) |=> $stable(sp_out)); // R10

    AST_SS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ss_out)); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> ($stable(pop_word) && $stable(pc_out)
                                   && $stable(cs_out) && $stable(flags_out))); // R11
endmodule

bind stk_engine stk_chk #(.WW(WW), .SHIFT(SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .sp_wr     (sp_wr),
    .sp_out    (sp_out),
    .ss_out    (ss_out),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .pop_word  (pop_word),
    .pc_out    (pc_out),
    .cs_out    (cs_out),
    .flags_out (flags_out)
);

// File: tb/sim_stk_engine.sv
module sim_stk_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [15:0] cmd_data = '0, cmd_ret_pc = '0, cmd_cs = '0, cmd_flags = '0;
    logic [15:0] cmd_tgt_pc = '0, cmd_tgt_cs = '0;
    logic        sp_wr = 1'b0, ss_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        busy, done;
    logic [15:0] sp_out, ss_out, pop_word, pc_out, cs_out, flags_out;
    logic [19:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  bmem [0:4095];
    logic [7:0]  rmem [0:4095];
    logic        clr_mem = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [15:0] ref_sp, ref_ss, ref_pop, ref_pc, ref_cs, ref_flg;
    bit inject = 1'b0;
    bit also_wr = 1'b0;

    stk_engine #(.SP_RST(16'h0002), .SS_RST(16'hFFFF)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ret_pc(cmd_ret_pc), .cmd_cs(cmd_cs),
        .cmd_flags(cmd_flags), .cmd_tgt_pc(cmd_tgt_pc), .cmd_tgt_cs(cmd_tgt_cs),
        .sp_wr(sp_wr), .ss_wr(ss_wr), .wr_data(wr_data),
        .busy(busy), .done(done), .sp_out(sp_out), .ss_out(ss_out),
        .pop_word(pop_word), .pc_out(pc_out), .cs_out(cs_out), .flags_out(flags_out),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (clr_mem) begin
            for (int i = 0; i < 4096; i++) bmem[i] <= 8'h00;
        end else if (mem_we) begin
            bmem[mem_addr[11:0]] <= mem_wdata;
        end
    end
    assign mem_rdata = bmem[mem_addr[11:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input int op, input logic [15:0] d, input logic [15:0] ret,
                       input logic [15:0] cs, input logic [15:0] fl,
                       input logic [15:0] tpc, input logic [15:0] tcs);
        int nw;
        bit ispush;
        logic [15:0] w [3];
        logic [15:0] got [3];
        logic [15:0] ofs;
        logic [19:0] pa, pb;
        logic [7:0]  eb;
        nw = (op == 4 || op == 5) ? 3 : 1;
        ispush = (op == 0 || op == 2 || op == 4);
        w[0] = (op == 0) ? d : (op == 2) ? ret : fl;
        w[1] = cs;
        w[2] = ret;
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_data = d; cmd_ret_pc = ret;
        cmd_cs = cs; cmd_flags = fl; cmd_tgt_pc = tpc; cmd_tgt_cs = tcs;
        if (also_wr) begin sp_wr = 1'b1; wr_data = 16'h7777; end
        @(negedge clk);
        cmd_valid = 1'b0; sp_wr = 1'b0;
        chk("R8 busy after accept", {31'd0, busy}, 32'd1);
        for (int wi = 0; wi < nw; wi++) begin
            for (int b = 0; b < 2; b++) begin
                if (ispush) begin
                    ofs = (b == 1) ? ref_sp - 16'd2 : ref_sp - 16'd1;
                    eb  = (b == 1) ? w[wi][7:0] : w[wi][15:8];
                    pa  = phys(ref_ss, ofs);
                    chk("R1 push write strobe", {31'd0, mem_we}, 32'd1);
                    chk("R3 push address", {12'd0, mem_addr}, {12'd0, pa});
                    chk("R1 push byte", {24'd0, mem_wdata}, {24'd0, eb});
                    rmem[pa[11:0]] = eb;
                    if (b == 1) ref_sp = ref_sp - 16'd2;
                end else begin
                    ofs = (b == 1) ? ref_sp + 16'd1 : ref_sp;
                    pa  = phys(ref_ss, ofs);
                    chk("R2 pop read strobe", {31'd0, mem_re}, 32'd1);
                    chk("R3 pop address", {12'd0, mem_addr}, {12'd0, pa});
                    if (b == 1) begin
                        pb = phys(ref_ss, ref_sp);
                        got[wi] = {rmem[pa[11:0]], rmem[pb[11:0]]};
                        ref_sp = ref_sp + 16'd2;
                    end
                end
                if (inject && wi == 0 && b == 0) begin
                    cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 16'hDEAD;
                end
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        end
        chk("R8 done pulse", {31'd0, done}, 32'd1);
        chk("R8 busy low at done", {31'd0, busy}, 32'd0);
        chk("R1 R2 sp after command", {16'd0, sp_out}, {16'd0, ref_sp});
        case (op)
            1: ref_pop = got[0];
            2: ref_pc = tpc;
            3: ref_pc = got[0];
            4: begin ref_pc = tpc; ref_cs = tcs; end
            5: begin ref_pc = got[0]; ref_cs = got[1]; ref_flg = got[2]; end
            default: ;
        endcase
        chk("R2 R11 pop_word", {16'd0, pop_word}, {16'd0, ref_pop});
        chk("R4 R5 R6 R7 pc_out", {16'd0, pc_out}, {16'd0, ref_pc});
        chk("R6 R7 cs_out", {16'd0, cs_out}, {16'd0, ref_cs});
        chk("R7 flags_out", {16'd0, flags_out}, {16'd0, ref_flg});
        @(negedge clk);
        chk("R8 done single cycle", {31'd0, done}, 32'd0);
        chk("R9 no extra command", {31'd0, busy}, 32'd0);
        chk("R9 sp held after command", {16'd0, sp_out}, {16'd0, ref_sp});
    endtask

    initial begin
        logic [15:0] hold_pop;
        logic [15:0] hold_pc;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 4096; i++) rmem[i] = 8'h00;
        ref_sp = 16'h0002; ref_ss = 16'hFFFF;
        ref_pop = '0; ref_pc = '0; ref_cs = '0; ref_flg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr_mem = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset sp", {16'd0, sp_out}, 32'h0002);
        chk("R10 reset ss", {16'd0, ss_out}, 32'hFFFF);
        chk("R10 reset busy", {31'd0, busy}, 32'd0);
        chk("R10 reset done", {31'd0, done}, 32'd0);
        chk("R10 reset pc_out", {16'd0, pc_out}, 32'd0);
        chk("R10 reset pop_word", {16'd0, pop_word}, 32'd0);

        // R1 R3 pushes crossing the pointer and physical wraps
        run(0, 16'hA5C3, 0, 0, 0, 0, 0);
        run(0, 16'h1234, 0, 0, 0, 0, 0);
        chk("R3 wrapped address value", {12'd0, phys(16'hFFFF, 16'hFFFE)}, 32'h0FFEE);
        // R2 pops back in reverse
        run(1, 0, 0, 0, 0, 0, 0);
        chk("R2 last pushed first", {16'd0, pop_word}, 32'h1234);
        run(1, 0, 0, 0, 0, 0, 0);
        chk("R2 first pushed last", {16'd0, pop_word}, 32'hA5C3);

        // R10 direct loads
        sp_wr = 1'b1; wr_data = 16'h0100;
        @(negedge clk);
        sp_wr = 1'b0; ss_wr = 1'b1; wr_data = 16'h0040;
        @(negedge clk);
        ss_wr = 1'b0;
        ref_sp = 16'h0100; ref_ss = 16'h0040;
        chk("R10 sp load", {16'd0, sp_out}, 32'h0100);
        chk("R10 ss load", {16'd0, ss_out}, 32'h0040);

        // R10 write ignored when a command is accepted the same cycle
        also_wr = 1'b1;
        run(0, 16'hBEEF, 0, 0, 0, 0, 0);
        also_wr = 1'b0;

        // R4 call and R5 return
        run(2, 0, 16'h0203, 0, 0, 16'h4000, 0);
        run(3, 0, 0, 0, 0, 0, 0);
        chk("R5 return offset", {16'd0, pc_out}, 32'h0203);

        // R6 interrupt entry and R7 interrupt return
        run(4, 0, 16'h2222, 16'h1111, 16'h0246, 16'h3333, 16'h4444);
        run(5, 0, 0, 0, 0, 0, 0);
        chk("R7 pc restored", {16'd0, pc_out}, 32'h2222);
        chk("R7 cs restored", {16'd0, cs_out}, 32'h1111);
        chk("R7 flags restored", {16'd0, flags_out}, 32'h0246);

        // R9 command while busy is ignored
        inject = 1'b1;
        run(0, 16'h5A5A, 0, 0, 0, 0, 0);
        inject = 1'b0;

        // R9 unused opcodes
        for (int k = 6; k < 8; k++) begin
            cmd_valid = 1'b1; cmd_op = 3'(k);
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R9 bad opcode no busy", {31'd0, busy}, 32'd0);
            chk("R9 bad opcode no access", {30'd0, mem_we, mem_re}, 32'd0);
            @(negedge clk);
            chk("R9 bad opcode sp", {16'd0, sp_out}, {16'd0, ref_sp});
            chk("R9 bad opcode done", {31'd0, done}, 32'd0);
        end

        // R11 outputs hold across unrelated commands
        run(1, 0, 0, 0, 0, 0, 0);
        hold_pop = pop_word;
        hold_pc = pc_out;
        run(0, 16'h0F0F, 0, 0, 0, 0, 0);
        chk("R11 pop_word held over push", {16'd0, pop_word}, {16'd0, hold_pop});
        chk("R11 pc_out held over push", {16'd0, pc_out}, {16'd0, hold_pc});

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            op = int'($urandom % 6);
            if (($urandom % 8) == 0) begin
                sp_wr = 1'b1; wr_data = 16'($urandom);
                @(negedge clk);
                sp_wr = 1'b0;
                ref_sp = wr_data;
                chk("R10 random sp load", {16'd0, sp_out}, {16'd0, ref_sp});
            end
            run(op, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                16'($urandom), 16'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule